// File: doc/BRIEF.md
# Low-Supply Processor Hold Supervisor

This block decides, on every edge of the 32768 Hz slow clock, whether the processor may run while the chip lives on its backup battery. It watches a coded supply-status word. When that word reports that the core rail has sagged below its working floor, the block opens a short grace window. During this window firmware can ask for sleep. If firmware does not ask, the block forces the processor into reset and switches the chip into a low-current brownout configuration.

The block also screens wake-ups from the dormant state. If system power is absent and the supply-good comparator reads low, the processor is not released. The block parks it in the same brownout hold and waits for the rail to recover or for system power to return. When the processor comes out of that hold, a sticky flag tells firmware that it is recovering from a bad supply. This flag clears only when the run signal next drops.

Top module: `lsh_supervisor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the outputs are `proc_wake`=1, `brownout_sel`=0 and `badsup_flag`=0.
- R2: While running without system power, the supervisor starts a hold once the status code reads the low value 3'b101 on GRACE_CYC (4) consecutive edges with no sleep request. After the 4th such edge, `proc_wake`=0 and `brownout_sel`=1.
- R3: If the status code holds any value other than 3'b101 on an edge before the count completes, the count restarts. No hold follows until 4 fresh consecutive low samples have been seen.
- R4: A sleep request sampled high while running drives `proc_wake`=0 with `brownout_sel`=0 after that edge. This is true even on the edge that would otherwise complete the grace count.
- R5: While `sys_pwr` is high, the low status code has no effect, and the processor keeps running.
- R6: While asleep, a wake event with `sys_pwr` high or `vdd_ok` high returns the processor to run (`proc_wake`=1, `brownout_sel`=0) on that edge.
- R7: While asleep, a wake event with `sys_pwr` low and `vdd_ok` low keeps `proc_wake`=0 and sets `brownout_sel`=1.
- R8: While in the brownout hold, the outputs stay unchanged until `vdd_ok` or `sys_pwr` is sampled high. On that edge the processor is released: `proc_wake`=1, `brownout_sel`=0 and `badsup_flag`=1.
- R9: `badsup_flag` keeps its value while `proc_wake` stays 1. It clears on the edge where `proc_wake` falls.
- R10: While asleep, the outputs do not change unless a wake event is sampled. While in the hold, a sleep request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst | input | 1 | Synchronous active-high master reset |
| supply_code | input | CODE_W | Supply-status code; LOW_CODE (3'b101) means the core rail is too low |
| sys_pwr | input | 1 | System power present |
| sleep_req | input | 1 | Firmware sleep request, sampled as a level |
| wake_evt | input | 1 | Wake event from the dormant state |
| vdd_ok | input | 1 | Supply-good comparator output |
| proc_wake | output | 1 | Processor run enable, active-low hold (1 = running) |
| brownout_sel | output | 1 | Brownout configuration select, high while the processor is held |
| badsup_flag | output | 1 | Sticky flag for recovery from a bad supply |

## Verification
A wrong internal count would show at `proc_wake` as a hold that arrives one edge early or late relative to the fourth consecutive low sample. It would also show as a missing restart after the code briefly recovers. Both are visible on the edge where the count should have completed. A state register stuck in the wrong mode would show at `brownout_sel` and `proc_wake` together on the first edge after the next wake event or supply recovery. A mis-kept sticky flag would show at `badsup_flag` either on release from the hold or on the edge where `proc_wake` falls.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_HOLD  = 2'd2
  } sup_state_e;
endpackage

// File: rtl/lsh_grace_timer.sv
module lsh_grace_timer #(
  parameter int GRACE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expire
);
  localparam int CW = $clog2(GRACE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

  logic [CW-1:0] cnt_q;

  // expire marks the edge that would complete the run of consecutive armed samples
  assign expire = arm && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!arm || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lsh_ctrl.sv
module lsh_ctrl
  import lsh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sys_pwr,
  input  logic sleep_req,
  input  logic wake_evt,
  input  logic vdd_ok,
  input  logic expire,
  output sup_state_e state_q,
  output logic wake_q,
  output logic wake_d,
  output logic brn_q,
  output logic release_hold
);
  sup_state_e state_d;

  always_comb begin
    state_d      = state_q;
    release_hold = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        // sleep wins over a hold that would start on the same edge
        if (sleep_req)   state_d = ST_SLEEP;
        else if (expire) state_d = ST_HOLD;
      end
      ST_SLEEP: begin
        if (wake_evt) begin
          if (sys_pwr || vdd_ok) state_d = ST_RUN;
          else                   state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (sys_pwr || vdd_ok) begin
          state_d      = ST_RUN;
          release_hold = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign wake_d = (state_d == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b1;
      brn_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      brn_q   <= (state_d == ST_HOLD);
    end
  end
endmodule

// File: rtl/lsh_flag.sv
module lsh_flag (
  input  logic clk,
  input  logic rst,
  input  logic wake_q,
  input  logic wake_d,
  input  logic release_hold,
  output logic flag_q
);
  logic wake_falls;
  assign wake_falls = wake_q && !wake_d;

  always_ff @(posedge clk) begin
    if (rst)               flag_q <= 1'b0;
    else if (wake_falls)   flag_q <= 1'b0;
    else if (release_hold) flag_q <= 1'b1;
  end
endmodule

// File: rtl/lsh_supervisor.sv
module lsh_supervisor
  import lsh_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] LOW_CODE = 3'b101,
  parameter int GRACE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] supply_code,
  input  logic              sys_pwr,
  input  logic              sleep_req,
  input  logic              wake_evt,
  input  logic              vdd_ok,
  output logic              proc_wake,
  output logic              brownout_sel,
  output logic              badsup_flag
);
  sup_state_e st;
  logic low_evt, arm, expire, wake_d, release_hold;

  // the low code counts only while the battery carries the chip
  assign low_evt = !sys_pwr && (supply_code == LOW_CODE);
  assign arm     = (st == ST_RUN) && low_evt;

  lsh_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm),
    .expire (expire)
  );

  lsh_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sys_pwr      (sys_pwr),
    .sleep_req    (sleep_req),
    .wake_evt     (wake_evt),
    .vdd_ok       (vdd_ok),
    .expire       (expire),
    .state_q      (st),
    .wake_q       (proc_wake),
    .wake_d       (wake_d),
    .brn_q        (brownout_sel),
    .release_hold (release_hold)
  );

  lsh_flag u_flag (
    .clk          (clk),
    .rst          (rst),
    .wake_q       (proc_wake),
    .wake_d       (wake_d),
    .release_hold (release_hold),
    .flag_q       (badsup_flag)
  );
endmodule

// File: rtl/lsh_supervisor_chk.sv
module lsh_supervisor_chk #(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] LOW_CODE = 3'b101,
  parameter int GRACE_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] supply_code,
  input logic              sys_pwr,
  input logic              sleep_req,
  input logic              wake_evt,
  input logic              vdd_ok,
  input logic              proc_wake,
  input logic              brownout_sel,
  input logic              badsup_flag
);
  localparam int KW = $clog2(GRACE_CYC + 1) + 1;
  logic [KW-1:0] run_low;
  logic low_run_cond;

  assign low_run_cond = proc_wake && !sys_pwr && (supply_code == LOW_CODE) && !sleep_req;

  always_ff @(posedge clk) begin
    if (rst || !low_run_cond) run_low <= '0;
    else if (run_low != KW'(GRACE_CYC)) run_low <= run_low + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (proc_wake && !brownout_sel && !badsup_flag));

  // R2
  grace_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (low_run_cond && run_low == KW'(GRACE_CYC - 1)) |=> (!proc_wake && brownout_sel));

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_wake && sleep_req) |=> (!proc_wake && !brownout_sel));

  // R7
  brn_means_held_chk: assert property (@(posedge clk) disable iff (rst)
    brownout_sel |-> !proc_wake);

  // R8
  release_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(proc_wake) && $past(brownout_sel)) |-> badsup_flag);

  // R9
  flag_clear_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(proc_wake) |-> !badsup_flag);

  // R9
  flag_steady_run_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_wake && $past(proc_wake)) |-> $stable(badsup_flag));
endmodule

bind lsh_supervisor lsh_supervisor_chk #(
  .CODE_W(CODE_W), .LOW_CODE(LOW_CODE), .GRACE_CYC(GRACE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .supply_code(supply_code), .sys_pwr(sys_pwr),
  .sleep_req(sleep_req), .wake_evt(wake_evt), .vdd_ok(vdd_ok),
  .proc_wake(proc_wake), .brownout_sel(brownout_sel), .badsup_flag(badsup_flag)
);

// File: tb/tb_lsh_supervisor.sv
module tb_lsh_supervisor;
  localparam int CLK_P = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] supply_code = 3'd0;
  logic sys_pwr = 1'b1, sleep_req = 1'b0, wake_evt = 1'b0, vdd_ok = 1'b1;
  logic proc_wake, brownout_sel, badsup_flag;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  lsh_supervisor dut (
    .clk(clk), .rst(rst), .supply_code(supply_code), .sys_pwr(sys_pwr),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .vdd_ok(vdd_ok),
    .proc_wake(proc_wake), .brownout_sel(brownout_sel), .badsup_flag(badsup_flag)
  );

  // driver: apply one edge of stimulus and queue the expected {wake, brn, flag}
  task automatic step(input logic s, input logic [2:0] c, input logic sl,
                      input logic ev, input logic vk, input logic [2:0] e,
                      input string tag);
    @(negedge clk);
    sys_pwr = s; supply_code = c; sleep_req = sl; wake_evt = ev; vdd_ok = vk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({proc_wake, brownout_sel, badsup_flag} !== e) begin
          errors++;
          $display("FAIL %s actual wake/brn/flag=%b expected=%b", t,
                   {proc_wake, brownout_sel, badsup_flag}, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state held while rst is high
    @(negedge clk);
    checks++;
    if ({proc_wake, brownout_sel, badsup_flag} !== 3'b100) begin
      errors++;
      $display("FAIL R1 actual=%b expected=100", {proc_wake, brownout_sel, badsup_flag});
    end
    rst = 1'b0;
    step(1, 3'd0, 0, 0, 1, 3'b100, "R1");
    // R5 low code with system power present
    for (int i = 0; i < 6; i++) step(1, 3'b101, 0, 0, 0, 3'b100, "R5");
    // R3 interrupted count, then fresh count
    for (int i = 0; i < 3; i++) step(0, 3'b101, 0, 0, 0, 3'b100, "R3");
    step(0, 3'b100, 0, 0, 0, 3'b100, "R3");
    for (int i = 0; i < 3; i++) step(0, 3'b101, 0, 0, 0, 3'b100, "R3");
    // R2 fourth consecutive low sample forces the hold
    step(0, 3'b101, 0, 0, 0, 3'b010, "R2");
    // R8 waiting in hold
    step(0, 3'b101, 0, 0, 0, 3'b010, "R8");
    step(0, 3'b000, 0, 1, 0, 3'b010, "R8");
    // R10 sleep request ignored in hold
    step(0, 3'b000, 1, 0, 0, 3'b010, "R10");
    // R8 release on supply good
    step(0, 3'b000, 0, 0, 1, 3'b101, "R8");
    // R9 flag holds while running
    for (int i = 0; i < 3; i++) step(1, 3'b000, 0, 0, 1, 3'b101, "R9");
    // R4 sleep request, R9 flag clears as wake falls
    step(1, 3'b000, 1, 0, 1, 3'b000, "R4");
    // R10 asleep, no wake event
    step(0, 3'b000, 0, 0, 1, 3'b000, "R10");
    step(1, 3'b101, 0, 0, 1, 3'b000, "R10");
    // R7 wake with bad supply and no system power
    step(0, 3'b101, 0, 1, 0, 3'b010, "R7");
    // R8 release on system power
    step(1, 3'b101, 0, 0, 0, 3'b101, "R8");
    step(1, 3'b000, 0, 0, 1, 3'b101, "R9");
    // R4 sleep wins on the edge that completes the count
    for (int i = 0; i < 3; i++) step(0, 3'b101, 0, 0, 0, 3'b101, "R4");
    step(0, 3'b101, 1, 0, 0, 3'b000, "R4");
    // R6 wake with supply good
    step(0, 3'b101, 0, 1, 1, 3'b100, "R6");
    // R6 wake with system power while supply reads bad
    step(0, 3'b000, 1, 0, 1, 3'b000, "R4");
    step(1, 3'b000, 0, 1, 0, 3'b100, "R6");
    step(1, 3'b000, 0, 0, 1, 3'b100, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule